// File: doc/BRIEF.md
# Frame-Sync Word Counter with Snapshot Capture

This block counts transitions of an audio word-select (frame-sync) line so that the average sample rate can be measured over a long interval. Every rising and every falling edge of the line adds one to a 10-bit counter. The counter stops at its full-scale value instead of wrapping. A capture event copies the running count into a capture register and clears the counter in the same clock cycle, so no edge is lost between intervals.

A capture event comes from one of two places. The first is a software strobe, which always works. The second is one of three hardware pulse inputs: a periodic 1 ms frame-start pulse, a timer compare pulse and a pin-transition pulse. A select code picks which hardware input is used, and code 0 turns off all hardware inputs.

The word-select input is taken as already synchronous to `clk`. A small state machine controls the block. Its states are:
- `ST_PRIME`: the first cycle after reset, which only loads the edge reference.
- `ST_COUNT`: normal counting.
- `ST_SAT`: the counter is held at full scale.

Its transitions are:
- prime-to-count: always taken after one cycle.
- count-to-sat: an edge takes the count from 1022 to 1023 with no capture in that cycle.
- sat-to-count: any capture event.

Top module: `fsync_word_counter`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture, the capture value is 0 and `sat_flag` is 0.
- R2: Each rising edge and each falling edge of `ws_in` adds one to the counter. A level difference seen in the first cycle after reset is not counted.
- R3: A capture event copies the count into the capture register and clears the counter on the same clock edge. Bits 7:0 of the captured value appear on `cap_lo` and bits 9:8 appear on `cap_hi`.
- R4: Select code 1 takes `trig_src[0]` (frame start), code 2 takes `trig_src[1]` (timer compare) and code 3 takes `trig_src[2]` (pin transition). Pulses on the sources that are not selected have no effect.
- R5: With select code 0, no `trig_src` pulse causes a capture. Only `sw_capture` does.
- R6: The counter stops at 1023. Further edges leave it at 1023 until a capture.
- R7: `sat_flag` rises on the clock edge on which the count reaches 1023. It falls on the clock edge on which the next capture is registered.
- R8: If an edge and a capture event fall in the same cycle, the capture holds the count without that edge and the counter restarts at 1.
- R9: A software strobe and a selected hardware pulse in the same cycle act as one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ws_in | input | 1 | Word-select line, synchronous to clk |
| trig_sel | input | 2 | Hardware trigger select code (0 = none) |
| trig_src | input | 3 | Single-cycle trigger pulses: [0] frame start, [1] timer compare, [2] pin transition |
| sw_capture | input | 1 | Software capture-and-clear strobe |
| cap_lo | output | 8 | Captured count bits 7:0 |
| cap_hi | output | 2 | Captured count bits 9:8 |
| sat_flag | output | 1 | Counter is held at full scale |

## Verification
The bench aims at the cycle in which an edge and a capture coincide. A design that counted the edge into the snapshot would report one too many, and a design that dropped it would restart at 0 instead of 1. It drives well over 1023 edges and captures afterwards. A wrapping counter would report a small residue instead of 1023, and a misplaced flag update would show `sat_flag` one cycle early or late. It also pulses every source that is not selected, and every source under code 0, while checking that the capture register is unchanged. It holds `ws_in` high through reset so that a design counting the first-cycle level difference returns 1 instead of 0.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_COUNT = 2'd1,
        ST_SAT   = 2'd2
    } fwc_state_e;

    localparam int FWC_LO_W = 8;

endpackage

// File: rtl/fwc_edge_detect.sv
module fwc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ws_in,
    output logic edge_o
);
    logic ws_ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_ref_q <= 1'b0;
        end else begin
            ws_ref_q <= ws_in;
        end
    end

    assign edge_o = ws_in ^ ws_ref_q;
endmodule

// File: rtl/fwc_trig_select.sv
module fwc_trig_select #(
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] trig_sel,
    input  logic [NSRC-1:0]  trig_src,
    output logic             hw_hit
);
    logic [NSRC-1:0] hit_vec;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            assign hit_vec[gi] = (trig_sel == SEL_W'(gi + 1)) & trig_src[gi];
        end
    endgenerate

    assign hw_hit = |hit_vec;
endmodule

// File: rtl/fwc_sat_counter.sv
module fwc_sat_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             edge_now,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            capture <= '0;
        end else if (clr) begin
            capture <= count;
            count   <= CNT_W'(edge_now);
        end else if (inc) begin
            count   <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fsync_word_counter.sv
module fsync_word_counter
    import fwc_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ws_in,
    input  logic [SEL_W-1:0]      trig_sel,
    input  logic [NSRC-1:0]       trig_src,
    input  logic                  sw_capture,
    output logic [FWC_LO_W-1:0]   cap_lo,
    output logic [CNT_W-FWC_LO_W-1:0] cap_hi,
    output logic                  sat_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - CNT_W'(1);

    fwc_state_e       state_q, state_d;
    logic             raw_edge, edge_valid, inc_en, hw_hit, cap_evt;
    logic [CNT_W-1:0] cnt_q, cap_q;

    fwc_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ws_in  (ws_in),
        .edge_o (raw_edge)
    );

    fwc_trig_select #(.NSRC(NSRC), .SEL_W(SEL_W)) u_trig (
        .trig_sel (trig_sel),
        .trig_src (trig_src),
        .hw_hit   (hw_hit)
    );

    assign cap_evt = sw_capture | hw_hit;

    fwc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cap_evt),
        .edge_now (edge_valid),
        .inc      (inc_en),
        .count    (cnt_q),
        .capture  (cap_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_COUNT;
            ST_COUNT: begin
                if (!cap_evt && edge_valid && cnt_q == CNT_PRE) begin
                    state_d = ST_SAT;
                end
            end
            ST_SAT: begin
                if (cap_evt) begin
                    state_d = ST_COUNT;
                end
            end
            default: state_d = ST_PRIME;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        edge_valid = 1'b0;
        inc_en     = 1'b0;
        sat_flag   = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                edge_valid = 1'b0;
            end
            ST_COUNT: begin
                edge_valid = raw_edge;
                inc_en     = raw_edge & ~cap_evt;
            end
            ST_SAT: begin
                edge_valid = raw_edge;
                sat_flag   = 1'b1;
            end
            default: begin
                edge_valid = 1'b0;
            end
        endcase
    end

    assign cap_lo = cap_q[FWC_LO_W-1:0];
    assign cap_hi = cap_q[CNT_W-1:FWC_LO_W];
endmodule

// File: rtl/fwc_checker.sv
module fwc_checker #(
    parameter int CNT_W = 10,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_capture,
    input logic [SEL_W-1:0] trig_sel,
    input logic             cap_evt,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] capture,
    input logic             sat_flag
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> capture == $past(count));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> count <= CNT_W'(1));

    a_r5_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == '0 && !sw_capture) |=> $stable(capture));

    a_r6_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !cap_evt) |=> count == MAXV);

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> ({1'b0, count} >= {1'b0, $past(count)}) &&
                     ({1'b0, count} <= {1'b0, $past(count)} + (CNT_W+1)'(1)));

    a_r7_flag_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |-> count == MAXV);
endmodule

bind fsync_word_counter fwc_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_capture (sw_capture),
    .trig_sel   (trig_sel),
    .cap_evt    (cap_evt),
    .count      (cnt_q),
    .capture    (cap_q),
    .sat_flag   (sat_flag)
);

// File: tb/fsync_word_counter_tb.sv
`timescale 1ns/1ps
module fsync_word_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ws_in = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic [2:0] trig_src = 3'd0;
    logic       sw_capture = 1'b0;
    logic [7:0] cap_lo;
    logic [1:0] cap_hi;
    logic       sat_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int ref_cnt = 0;
    int ref_cap = 0;
    bit ref_primed = 1'b0;
    bit ref_prev = 1'b0;

    always #10 clk = ~clk;

    fsync_word_counter u_dut (
        .clk(clk), .rst_n(rst_n), .ws_in(ws_in), .trig_sel(trig_sel),
        .trig_src(trig_src), .sw_capture(sw_capture),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .sat_flag(sat_flag)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt = 0; ref_cap = 0; ref_primed = 1'b0; ref_prev = 1'b0;
        end else begin
            bit ev;
            bit e;
            ev = sw_capture || (trig_sel == 2'd1 && trig_src[0]) ||
                 (trig_sel == 2'd2 && trig_src[1]) || (trig_sel == 2'd3 && trig_src[2]);
            e = ref_primed && (ws_in != ref_prev);
            if (ev) begin
                ref_cap = ref_cnt;
                ref_cnt = e ? 1 : 0;
            end else if (e && ref_cnt < 1023) begin
                ref_cnt = ref_cnt + 1;
            end
            ref_prev = ws_in;
            ref_primed = 1'b1;
        end
    end

    function automatic int cap_val();
        return {22'd0, cap_hi, cap_lo};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R3 capture vs model", cap_val(), ref_cap);
        chk("R7 sat_flag vs model", int'(sat_flag), (ref_cnt == 1023) ? 1 : 0);
    endtask

    task automatic toggle(input int n);
        for (int i = 0; i < n; i++) begin
            ws_in = ~ws_in;
            cyc();
        end
    endtask

    task automatic sw_pulse();
        sw_capture = 1'b1;
        cyc();
        sw_capture = 1'b0;
    endtask

    task automatic hw_pulse(input logic [2:0] m);
        trig_src = m;
        cyc();
        trig_src = 3'd0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset capture", cap_val(), 0);
        chk("R1 reset sat_flag", int'(sat_flag), 0);
        rst_n = 1'b1;
        cyc(); cyc();
        chk("R1 idle after reset", cap_val(), 0);
        sw_pulse();
        chk("R2 first-cycle level not counted", cap_val(), 0);

        toggle(5);
        sw_pulse();
        chk("R2 five edges", cap_val(), 5);

        toggle(300);
        trig_sel = 2'd1;
        hw_pulse(3'b001);
        chk("R3 low byte", int'(cap_lo), 44);
        chk("R3 high field", int'(cap_hi), 1);
        chk("R4 code 1 frame start", cap_val(), 300);

        trig_sel = 2'd2;
        toggle(3);
        hw_pulse(3'b101);
        chk("R4 unselected sources ignored", cap_val(), 300);
        hw_pulse(3'b010);
        chk("R4 code 2 timer compare", cap_val(), 3);

        trig_sel = 2'd3;
        toggle(2);
        hw_pulse(3'b011);
        chk("R4 code 3 ignores others", cap_val(), 3);
        hw_pulse(3'b100);
        chk("R4 code 3 pin transition", cap_val(), 2);

        trig_sel = 2'd0;
        toggle(4);
        hw_pulse(3'b111);
        chk("R5 code 0 blocks hardware", cap_val(), 2);
        sw_pulse();
        chk("R5 software still captures", cap_val(), 4);

        toggle(6);
        ws_in = ~ws_in;
        sw_pulse();
        chk("R8 coincident edge excluded", cap_val(), 6);
        sw_pulse();
        chk("R8 counter restarted at 1", cap_val(), 1);

        trig_sel = 2'd3;
        toggle(7);
        sw_capture = 1'b1; trig_src = 3'b100;
        cyc();
        sw_capture = 1'b0; trig_src = 3'd0;
        chk("R9 combined capture", cap_val(), 7);
        sw_pulse();
        chk("R9 only one clear", cap_val(), 0);

        toggle(1022);
        chk("R7 flag low at 1022", int'(sat_flag), 0);
        toggle(1);
        chk("R7 flag high at 1023", int'(sat_flag), 1);
        toggle(80);
        chk("R7 flag held", int'(sat_flag), 1);
        sw_pulse();
        chk("R6 saturated capture", cap_val(), 1023);
        chk("R6 low byte full", int'(cap_lo), 255);
        chk("R6 high field full", int'(cap_hi), 3);
        chk("R7 flag cleared by capture", int'(sat_flag), 0);

        toggle(1030);
        ws_in = ~ws_in;
        sw_pulse();
        chk("R8 coincident edge in saturation", cap_val(), 1023);
        sw_pulse();
        chk("R8 restart at 1 after saturation", cap_val(), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule